// File: doc/BRIEF.md
# Serial SAR Converter Controller

This block is the digital half of an 8-bit successive-approximation converter driven over a three-wire serial link. A host pulls the active-low select line down, then clocks in a start bit followed by a short channel-configuration word. The same serial clock then runs the conversion: one slot for the external multiplexer to settle, then one decision per clock, each taken from an external comparator that tests the analog input against the trial code this block presents to the ladder.

Decided bits stream out on the serial data line, most significant first, while they are resolved. Once the last bit is decided, a static pin picks the tail: either the least significant bit is held on the line, or the result is replayed starting from the least significant end, followed by zeros. Raising select aborts or ends a transaction and clears all state. The serial inputs pass through a synchronizer into the fast system clock domain. A parameter picks an 8-channel build (four configuration bits) or a 4-channel build (three bits, lowest select bit forced high).

Top module: `ssar_ctrl`

## Requirements
- R1: While `sel_n` is high, or `rst` is asserted, `busy`, `sdo`, `sdo_oe`, `mux_cfg` and `dac_code` are all zero.
- R2: Serial input is taken on rising serial-clock edges. Zeros ahead of the first one are skipped. That first one is the start bit. In the default 8-channel build the next four bits, in arrival order, become `mux_cfg[3]`, `mux_cfg[2]`, `mux_cfg[1]`, `mux_cfg[0]`. `busy` rises on the edge that takes the last of them.
- R3: After the start bit has been accepted, `sdi` has no effect on `mux_cfg` or `busy` until `sel_n` goes high again.
- R4: On the falling serial edge after `busy` rises, `sdo_oe` goes high and `sdo` is driven low for one serial period (the settling slot).
- R5: When `busy` rises, `dac_code` is 0x80. On each later rising edge, the bit under trial is kept if `cmp_hi` is high and cleared otherwise, and the next lower bit is set. After the eighth decision, `dac_code` holds the result.
- R6: `sdo` changes only after falling serial edges. After the falling edge that follows the j-th decision it shows the bit decided there, so the result leaves MSB first.
- R7: `busy` stays high for exactly eight serial periods and falls on the rising edge that decides bit 0.
- R8: With `tail_hold` high, `sdo` keeps the result's bit 0 on every later falling edge.
- R9: With `tail_hold` low, the seven falling edges after bit 0 present result bits 1 through 7 in that order, and later falling edges present zeros.
- R10: If `cmp_hi` stays low for every trial, the result and the streamed bits are all zero.
- R11: When `sel_n` goes high during a conversion, the conversion is abandoned. After `sel_n` goes low again, no conversion begins until a new start bit and configuration word arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in: start bit and configuration word |
| cmp_hi | input | 1 | Comparator result; high when the input is at or above the trial level |
| tail_hold | input | 1 | High holds bit 0 on the line; low replays the result from the low end |
| busy | output | 1 | High while a conversion is in progress |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the external tri-state driver of `sdo` |
| mux_cfg | output | 4 | Latched channel configuration for the analog multiplexer |
| dac_code | output | 8 | Trial code to the ladder; holds the result after the conversion |

## Verification
On every cycle, the assertions check the following: the clear state after select rises; the frozen configuration once the start bit is taken; the 0x80 seed when busy rises; the eight-period length of busy; `sdo` and its enable moving only after falling serial edges; the low settling bit; and the held tail. Only the bench scenarios can show that the decided values match an analog input, that the MSB-first stream and the LSB-first replay carry the right bits in the right order, and that an aborted transaction needs a fresh start bit. Those scenarios use a comparator model that follows the trial code.

// File: rtl/ssar_pkg.sv
package ssar_pkg;
  localparam int CFG_W = 4;
  typedef logic [CFG_W-1:0] cfg_t;
endpackage

// File: rtl/ssar_front.sv
module ssar_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic sdi_s,
  output logic clr
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE_VAL = 3'b100;

  logic [STAGES-1:0][W-1:0] stg;
  logic sclk_d;
  logic sel_s;
  logic sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_VAL;
      sclk_d <= 1'b0;
    end else begin
      stg[0] <= {sel_n, sclk, sdi};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= stg[STAGES-1][1];
    end
  end

  assign sel_s  = stg[STAGES-1][2];
  assign sclk_s = stg[STAGES-1][1];
  assign sdi_s  = stg[STAGES-1][0];
  assign rise   = sclk_s & ~sclk_d & ~sel_s;
  assign fall   = ~sclk_s & sclk_d & ~sel_s;
  assign clr    = rst | sel_s;
endmodule

// File: rtl/ssar_addr.sv
module ssar_addr
  import ssar_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rise,
  input  logic sdi,
  output logic start,
  output cfg_t cfg
);
  localparam int ABITS = (NUM_CH == 8) ? 4 : 3;

  logic [ABITS:0] sr;
  logic [ABITS:0] nxt;
  logic           taken;
  cfg_t           word;

  assign nxt   = {sr[ABITS-1:0], sdi};
  assign start = rise & ~taken & nxt[ABITS];

  generate
    if (NUM_CH == 8) begin : g_oct
      assign word = nxt[3:0];
    end else begin : g_quad
      assign word = {nxt[2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (clr) begin
      sr    <= '0;
      taken <= 1'b0;
      cfg   <= '0;
    end else if (rise && !taken) begin
      sr <= nxt;
      if (nxt[ABITS]) begin
        taken <= 1'b1;
        cfg   <= word;
      end
    end
  end

  // R3: configuration is frozen once the start bit has been taken
  assert_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (taken && !clr) |=> $stable(cfg));
endmodule

// File: rtl/ssar_sar.sv
module ssar_sar #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                rise,
  input  logic                start,
  input  logic                cmp_hi,
  output logic                busy,
  output logic [RES_BITS-1:0] code,
  output logic                dbit,
  output logic                done,
  output logic [RES_BITS-1:0] final_code
);
  localparam int PW = (RES_BITS > 1) ? $clog2(RES_BITS) : 1;
  localparam logic [RES_BITS-1:0] SEED = {1'b1, {(RES_BITS-1){1'b0}}};
  localparam logic [PW-1:0] TOP = PW'(RES_BITS - 1);

  logic [PW-1:0] ptr;

  assign done       = rise & busy & (ptr == '0);
  assign final_code = {code[RES_BITS-1:1], cmp_hi};

  always_ff @(posedge clk) begin
    if (clr) begin
      busy <= 1'b0;
      code <= '0;
      ptr  <= '0;
      dbit <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      code <= SEED;
      ptr  <= TOP;
      dbit <= 1'b0;
    end else if (rise && busy) begin
      code[ptr] <= cmp_hi;
      dbit      <= cmp_hi;
      if (ptr == '0) begin
        busy <= 1'b0;
      end else begin
        code[ptr - 1'b1] <= 1'b1;
        ptr              <= ptr - 1'b1;
      end
    end
  end

  // R5: the first trial code is the mid-scale seed
  assert_seed_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> code == SEED);
  // R7: busy ends only on the last decision
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && rise && ptr == '0 && !clr) |=> !busy);
  assert_busy_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !(rise && ptr == '0) && !clr) |=> busy);
endmodule

// File: rtl/ssar_dout.sv
module ssar_dout #(
  parameter int RES_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                fall,
  input  logic                busy,
  input  logic                dbit,
  input  logic                done,
  input  logic [RES_BITS-1:0] final_code,
  input  logic                tail_hold,
  output logic                sdo,
  output logic                sdo_oe
);
  logic                pend_last;
  logic                tail_mode;
  logic [RES_BITS-1:0] tail_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      pend_last <= 1'b0;
      tail_mode <= 1'b0;
      tail_q    <= '0;
    end else begin
      if (done) begin
        tail_q    <= final_code >> 1;
        pend_last <= 1'b1;
      end
      if (fall) begin
        if (busy) begin
          sdo_oe <= 1'b1;
          sdo    <= dbit;
        end else if (pend_last) begin
          sdo       <= dbit;
          pend_last <= 1'b0;
          tail_mode <= 1'b1;
        end else if (tail_mode && !tail_hold) begin
          sdo    <= tail_q[0];
          tail_q <= tail_q >> 1;
        end
      end
    end
  end

  // R6: the data line and its enable move only after a falling serial edge
  assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (!fall && !clr) |=> ($stable(sdo) && $stable(sdo_oe)));
  // R4: the first driven bit is the low settling slot
  assert_settle_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> !sdo);
  // R8: a held tail keeps the line still
  assert_tail_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (tail_mode && tail_hold && !clr) |=> $stable(sdo));
endmodule

// File: rtl/ssar_ctrl.sv
module ssar_ctrl
  import ssar_pkg::*;
#(
  parameter int RES_BITS    = 8,
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_n,
  input  logic                sclk,
  input  logic                sdi,
  input  logic                cmp_hi,
  input  logic                tail_hold,
  output logic                busy,
  output logic                sdo,
  output logic                sdo_oe,
  output logic [CFG_W-1:0]    mux_cfg,
  output logic [RES_BITS-1:0] dac_code
);
  logic rise, fall, sdi_s, clr;
  logic start, dbit, done;
  logic [RES_BITS-1:0] final_code;

  ssar_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .rise(rise), .fall(fall), .sdi_s(sdi_s), .clr(clr)
  );

  ssar_addr #(.NUM_CH(NUM_CH)) u_addr (
    .clk(clk), .rst(rst), .clr(clr), .rise(rise), .sdi(sdi_s),
    .start(start), .cfg(mux_cfg)
  );

  ssar_sar #(.RES_BITS(RES_BITS)) u_sar (
    .clk(clk), .rst(rst), .clr(clr), .rise(rise), .start(start),
    .cmp_hi(cmp_hi), .busy(busy), .code(dac_code), .dbit(dbit),
    .done(done), .final_code(final_code)
  );

  ssar_dout #(.RES_BITS(RES_BITS)) u_dout (
    .clk(clk), .rst(rst), .clr(clr), .fall(fall), .busy(busy),
    .dbit(dbit), .done(done), .final_code(final_code),
    .tail_hold(tail_hold), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  // R1: a deselect or reset leaves every output cleared
  assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!busy && !sdo && !sdo_oe && mux_cfg == '0 && dac_code == '0));
endmodule

// File: tb/ssar_ctrl_tb.sv
module ssar_ctrl_tb;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0] vin;
    logic [3:0] cfg;
    logic       hold;
    logic       neg;
    logic       noise;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'hA5, 4'b1000, 1'b0, 1'b0, 1'b1, 8'hA5},
    '{8'h5A, 4'b0110, 1'b1, 1'b0, 1'b0, 8'h5A},
    '{8'h00, 4'b1111, 1'b0, 1'b0, 1'b1, 8'h00},
    '{8'hFF, 4'b0001, 1'b0, 1'b0, 1'b0, 8'hFF},
    '{8'h80, 4'b1010, 1'b1, 1'b0, 1'b1, 8'h80},
    '{8'h7F, 4'b0101, 1'b0, 1'b0, 1'b1, 8'h7F},
    '{8'hC3, 4'b1100, 1'b0, 1'b1, 1'b1, 8'h00},
    '{8'h01, 4'b0011, 1'b1, 1'b0, 1'b0, 8'h01}
  };

  logic clk = 1'b0;
  logic rst, sel_n, sclk, sdi, tail_hold;
  logic cmp_hi;
  logic busy, sdo, sdo_oe;
  logic [3:0] mux_cfg;
  logic [7:0] dac_code;
  logic [7:0] vin_r;
  logic neg_r;
  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  always_comb cmp_hi = neg_r ? 1'b0 : (vin_r >= dac_code);

  ssar_ctrl u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .cmp_hi(cmp_hi), .tail_hold(tail_hold), .busy(busy), .sdo(sdo),
    .sdo_oe(sdo_oe), .mux_cfg(mux_cfg), .dac_code(dac_code)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic d);
    sdi  = d;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_head(input logic [3:0] cfg);
    pulse(1'b1);
    for (int i = 3; i >= 0; i--) pulse(cfg[i]);
  endtask

  task automatic check_cleared(input string tag);
    chk(tag, {busy, sdo, sdo_oe}, 3'b000);
    chk(tag, {mux_cfg, dac_code}, 12'h000);
  endtask

  task automatic run_conv(input vec_t v);
    logic [7:0] e;
    e = v.exp;
    vin_r = v.vin;
    neg_r = v.neg;
    tail_hold = v.hold;
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b0);
    pulse(1'b0);
    chk("R2 leading zeros", busy, 1'b0);
    send_head(v.cfg);
    chk("R2 busy at start", busy, 1'b1);
    chk("R2 cfg", mux_cfg, v.cfg);
    chk("R5 seed", dac_code, 8'h80);
    chk("R4 oe", sdo_oe, 1'b1);
    chk("R4 settle low", sdo, 1'b0);
    for (int j = 1; j <= 8; j++) begin
      pulse(v.noise);
      chk(v.neg ? "R10 msb stream" : "R6 msb stream", sdo, e[8-j]);
      chk("R7 busy", busy, (j < 8) ? 1'b1 : 1'b0);
    end
    chk(v.neg ? "R10 result" : "R5 result", dac_code, e);
    chk("R3 cfg kept", mux_cfg, v.cfg);
    for (int k = 1; k <= 9; k++) begin
      pulse(v.noise);
      if (v.hold) chk("R8 hold", sdo, e[0]);
      else chk("R9 replay", sdo, (k <= 7) ? e[k] : 1'b0);
    end
    send_head(4'b1111);
    chk("R3 no restart", busy, 1'b0);
    chk("R3 cfg after tail", mux_cfg, v.cfg);
    chk("R3 result kept", dac_code, e);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
    check_cleared("R1 deselect");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    sel_n = 1'b0;
    sclk = 1'b0;
    sdi = 1'b0;
    tail_hold = 1'b0;
    vin_r = 8'h00;
    neg_r = 1'b0;
    repeat (6) @(negedge clk);
    check_cleared("R1 reset");
    rst = 1'b0;
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    check_cleared("R1 idle deselected");

    for (int n = 0; n < NV; n++) run_conv(VECS[n]);

    // R11: abort mid-conversion, then confirm a new start bit is required
    vin_r = 8'h96;
    neg_r = 1'b0;
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    send_head(4'b1011);
    pulse(1'b0);
    pulse(1'b0);
    pulse(1'b0);
    chk("R11 in progress", busy, 1'b1);
    sel_n = 1'b1;
    repeat (6) @(negedge clk);
    check_cleared("R11 abort");
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 6; i++) pulse(1'b0);
    chk("R11 no spurious start", {busy, sdo_oe}, 2'b00);
    chk("R11 trial idle", dac_code, 8'h00);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
    run_conv('{8'h96, 4'b1011, 1'b0, 1'b0, 1'b0, 8'h96});

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule